// File: doc/BRIEF.md
# External Interrupt Edge Flag Controller

This block watches a bank of external interrupt request pins plus one non-maskable interrupt pin. Each pin is first passed through a multi-flop synchroniser. A change between two consecutive synchronised samples counts as an edge. Every request pin has its own rising-edge enable and falling-edge enable. When an enabled edge is seen, a sticky status flag is set. That flag is set whatever the request enables hold.

Software reaches the block through a simple word-addressed register port with a combinational read. It reads the status word and clears flags by writing ones to them. It also programs the edge enables, a per-pin request enable and a per-pin DMA-select bit. An enabled flag whose DMA-select bit is clear drives the single shared interrupt line. An enabled flag whose DMA-select bit is set drives that pin's own DMA request instead, and the matching DMA acknowledge clears the flag. The non-maskable flag is set on a rising edge of its pin and drives a dedicated output with no gating.

Top module: `ext_irq_flag_ctrl`

## Requirements
- R1: A rising edge on request pin n sets status bit n when rising-enable bit n is 1, and a falling edge sets it when falling-enable bit n is 1. With the default two synchroniser stages, a pin change driven before clock edge k is visible in the status read after clock edge k+2.
- R2: An edge on a pin whose rising and falling enables are both 0 leaves its status bit at 0.
- R3: A status flag sets on a qualifying edge even when its request enable bit is 0, and it then raises no output.
- R4: Writing the status word (word index 0) clears every flag whose written bit is 1. Bits written as 0 leave their flags unchanged.
- R5: A set flag stays set, with no further edges, until a write-one clear or a DMA acknowledge removes it.
- R6: Status word layout: flag n is at bit n (n from 0 up to the pin count minus 1), the non-maskable flag is at bit 31, and all bits in between read 0 and ignore writes.
- R7: After reset all flags, all enable registers and all outputs are 0.
- R8: irq_o is 1 exactly when some flag n is set with request-enable bit n equal to 1 and DMA-select bit n equal to 0.
- R9: dma_req_o[n] is 1 when flag n, request-enable bit n and DMA-select bit n are all 1, and such a flag does not drive irq_o. dma_ack_i[n] high at a clock edge clears flag n at that edge.
- R10: When a qualifying edge and a clear (a write-one or an acknowledge) reach the same flag at the same clock edge, the flag ends up set.
- R11: A rising edge on nmi_pin_i sets status bit 31, and a falling edge does not. nmi_o follows that flag regardless of any enable register, until bit 31 is written with 1.
- R12: The register map is by word index: 0 status, 1 rising enables, 2 falling enables, 3 request enables, 4 DMA selects. The enable registers read back what was written in bits 0 up to the pin count minus 1, and the unused indices 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_pin_i | input | NUM_IRQ | Asynchronous external request pins |
| nmi_pin_i | input | 1 | Asynchronous non-maskable interrupt pin |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| dma_ack_i | input | NUM_IRQ | Per-pin DMA service acknowledge |
| irq_o | output | 1 | Shared interrupt request |
| dma_req_o | output | NUM_IRQ | Per-pin DMA request |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
The hardest case to reach from the ports is a qualifying edge that lands on the same clock edge as a clear of the same flag. The edge only emerges after the synchroniser and the previous-sample register. To line the two up, the bench changes the pin and then counts two clock edges. It drives the write-one clear, and in a second run the DMA acknowledge, so that the clear is sampled on exactly the edge where the detector fires. It then reads back the status word to confirm that the flag survived.

// File: rtl/eif_pkg.sv
package eif_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int NMI_BIT = 31;

  typedef enum logic [ADDR_W-1:0] {
    EIF_A_STATUS = 3'd0,
    EIF_A_RISE   = 3'd1,
    EIF_A_FALL   = 3'd2,
    EIF_A_REQEN  = 3'd3,
    EIF_A_DMASEL = 3'd4
  } eif_addr_e;
endpackage

// File: rtl/eif_sync.sv
module eif_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stage_d[g] = d;
    end else begin : g_rest
      assign stage_d[g] = stage_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d[g];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/eif_edge.sv
module eif_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= smp;
  end

  always_comb begin
    hit = (smp & ~prev_q & rise_en) | (~smp & prev_q & fall_en);
  end
endmodule

// File: rtl/eif_flags.sv
module eif_flags #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flag
);
  logic [W-1:0] flag_q;
  logic [W-1:0] flag_d;

  // a new event outranks a clear so it is never dropped
  always_comb begin
    flag_d = (flag_q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/eif_regs.sv
module eif_regs
  import eif_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [NUM_IRQ-1:0] flags,
  input  logic               nmi_flag,
  output logic [NUM_IRQ-1:0] rise_en,
  output logic [NUM_IRQ-1:0] fall_en,
  output logic [NUM_IRQ-1:0] req_en,
  output logic [NUM_IRQ-1:0] dma_sel,
  output logic [NUM_IRQ-1:0] flag_w1c,
  output logic               nmi_w1c,
  output logic [DATA_W-1:0]  bus_rdata
);
  logic [NUM_IRQ-1:0] rise_q, fall_q, reqen_q, dmasel_q;
  logic               we_status, we_rise, we_fall, we_reqen, we_dmasel;
  logic [NUM_IRQ-1:0] wr_bits;
  logic               unused_wdata;

  assign wr_bits      = bus_wdata[NUM_IRQ-1:0];
  assign unused_wdata = ^bus_wdata[NMI_BIT-1:NUM_IRQ];

  always_comb begin
    we_status = bus_wr && (bus_addr == EIF_A_STATUS);
    we_rise   = bus_wr && (bus_addr == EIF_A_RISE);
    we_fall   = bus_wr && (bus_addr == EIF_A_FALL);
    we_reqen  = bus_wr && (bus_addr == EIF_A_REQEN);
    we_dmasel = bus_wr && (bus_addr == EIF_A_DMASEL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q   <= '0;
      fall_q   <= '0;
      reqen_q  <= '0;
      dmasel_q <= '0;
    end else begin
      if (we_rise)   rise_q   <= wr_bits;
      if (we_fall)   fall_q   <= wr_bits;
      if (we_reqen)  reqen_q  <= wr_bits;
      if (we_dmasel) dmasel_q <= wr_bits;
    end
  end

  assign rise_en  = rise_q;
  assign fall_en  = fall_q;
  assign req_en   = reqen_q;
  assign dma_sel  = dmasel_q;
  assign flag_w1c = we_status ? wr_bits : '0;
  assign nmi_w1c  = we_status & bus_wdata[NMI_BIT];

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      EIF_A_STATUS: begin
        bus_rdata[NUM_IRQ-1:0] = flags;
        bus_rdata[NMI_BIT]     = nmi_flag;
      end
      EIF_A_RISE:   bus_rdata[NUM_IRQ-1:0] = rise_q;
      EIF_A_FALL:   bus_rdata[NUM_IRQ-1:0] = fall_q;
      EIF_A_REQEN:  bus_rdata[NUM_IRQ-1:0] = reqen_q;
      EIF_A_DMASEL: bus_rdata[NUM_IRQ-1:0] = dmasel_q;
      default:      bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ext_irq_flag_ctrl.sv
module ext_irq_flag_ctrl
  import eif_pkg::*;
#(
  parameter int NUM_IRQ     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_pin_i,
  input  logic               nmi_pin_i,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_IRQ-1:0] dma_ack_i,
  output logic               irq_o,
  output logic [NUM_IRQ-1:0] dma_req_o,
  output logic               nmi_o
);
  localparam int SYNC_W = NUM_IRQ + 1;

  logic [SYNC_W-1:0]  pins_sync;
  logic [NUM_IRQ-1:0] irq_smp, set_vec, flag_q, clr_vec;
  logic [NUM_IRQ-1:0] rise_en, fall_en, req_en, dma_sel, flag_w1c;
  logic [NUM_IRQ-1:0] armed;
  logic               nmi_smp, nmi_set, nmi_w1c, nmi_flag;

  eif_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({nmi_pin_i, irq_pin_i}), .q(pins_sync)
  );
  assign irq_smp = pins_sync[NUM_IRQ-1:0];
  assign nmi_smp = pins_sync[NUM_IRQ];

  eif_edge #(.W(NUM_IRQ)) u_edge_irq (
    .clk(clk), .rst_n(rst_n), .smp(irq_smp),
    .rise_en(rise_en), .fall_en(fall_en), .hit(set_vec)
  );

  eif_edge #(.W(1)) u_edge_nmi (
    .clk(clk), .rst_n(rst_n), .smp(nmi_smp),
    .rise_en(1'b1), .fall_en(1'b0), .hit(nmi_set)
  );

  assign clr_vec = flag_w1c | dma_ack_i;

  eif_flags #(.W(NUM_IRQ)) u_flags_irq (
    .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(clr_vec), .flag(flag_q)
  );

  eif_flags #(.W(1)) u_flags_nmi (
    .clk(clk), .rst_n(rst_n), .set(nmi_set), .clr(nmi_w1c), .flag(nmi_flag)
  );

  eif_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .flags(flag_q), .nmi_flag(nmi_flag),
    .rise_en(rise_en), .fall_en(fall_en), .req_en(req_en), .dma_sel(dma_sel),
    .flag_w1c(flag_w1c), .nmi_w1c(nmi_w1c), .bus_rdata(bus_rdata)
  );

  assign armed     = flag_q & req_en;
  assign irq_o     = |(armed & ~dma_sel);
  assign dma_req_o = armed & dma_sel;
  assign nmi_o     = nmi_flag;
endmodule

// File: rtl/eif_checker.sv
module eif_checker
  import eif_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_IRQ-1:0] set_vec,
  input logic [NUM_IRQ-1:0] flag_q,
  input logic               nmi_set,
  input logic [NUM_IRQ-1:0] dma_ack_i,
  input logic               irq_o,
  input logic [NUM_IRQ-1:0] dma_req_o,
  input logic               nmi_o
);
  localparam logic [DATA_W-1:0] RSV_MASK =
    ~(({DATA_W{1'b1}} >> (DATA_W - NUM_IRQ)) | (DATA_W'(1) << NMI_BIT));

  logic st_wr;
  assign st_wr = bus_wr && (bus_addr == EIF_A_STATUS);

  p_edge_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

  p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && ((bus_wdata[NUM_IRQ-1:0] & set_vec) != '0))
      |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

  p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> ((flag_q & $past(bus_wdata[NUM_IRQ-1:0] & ~set_vec)) == '0));

  p_flag_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_wr && (dma_ack_i == '0)) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  p_dma_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_o & ~flag_q) == '0);

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_q != '0));

  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == EIF_A_STATUS) |-> ((bus_rdata & RSV_MASK) == '0));

  p_nmi_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_set |=> nmi_o);

  p_nmi_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_o && !(st_wr && bus_wdata[NMI_BIT])) |=> nmi_o);
endmodule

bind ext_irq_flag_ctrl eif_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .set_vec(set_vec),
  .flag_q(flag_q), .nmi_set(nmi_set), .dma_ack_i(dma_ack_i),
  .irq_o(irq_o), .dma_req_o(dma_req_o), .nmi_o(nmi_o)
);

// File: tb/sim_ext_irq_flag_ctrl.sv
module sim_ext_irq_flag_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk;
  logic        rst_n;
  logic [N-1:0] irq_pin_i;
  logic        nmi_pin_i;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [N-1:0] dma_ack_i;
  logic        irq_o;
  logic [N-1:0] dma_req_o;
  logic        nmi_o;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  typedef struct {
    int          kind;   // 0: read data, 1: {nmi_o, irq_o, dma_req_o}
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  ext_irq_flag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_pin_i(irq_pin_i), .nmi_pin_i(nmi_pin_i),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dma_ack_i(dma_ack_i), .irq_o(irq_o),
    .dma_req_o(dma_req_o), .nmi_o(nmi_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: compares queued expectations shortly after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = (it.kind == 0) ? bus_rdata : {14'd0, nmi_o, irq_o, dma_req_o};
        tests++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic chk_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    bus_addr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk);
  endtask

  task automatic chk_out(input logic nmi, input logic irq, input logic [N-1:0] dma,
                         input string tag);
    exp_t it;
    @(negedge clk);
    it.kind = 1; it.exp = {14'd0, nmi, irq, dma}; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pins(input logic [N-1:0] v);
    @(negedge clk);
    irq_pin_i = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic nmi_pin(input logic v);
    @(negedge clk);
    nmi_pin_i = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_pin_i = '0; nmi_pin_i = 1'b0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; dma_ack_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state
    chk_reg(3'd0, 32'h0, "R7 status");
    chk_reg(3'd1, 32'h0, "R7 rise enable");
    chk_out(1'b0, 1'b0, '0, "R7 outputs");

    // R1 / R3 edges with request enables off
    wr(3'd1, 32'h0001);
    wr(3'd2, 32'h0002);
    pins(16'h0003);
    chk_reg(3'd0, 32'h1, "R1 rising edge");
    chk_out(1'b0, 1'b0, '0, "R3 flag set, no output");
    pins(16'h0000);
    chk_reg(3'd0, 32'h3, "R1 falling edge");

    // R2 pin with no enables
    pins(16'h0004);
    pins(16'h0000);
    chk_reg(3'd0, 32'h3, "R2 disabled pin");

    // R4 write-one-clear, R5 hold
    wr(3'd0, 32'h2);
    chk_reg(3'd0, 32'h1, "R4 w1c one bit");
    wr(3'd0, 32'h0);
    chk_reg(3'd0, 32'h1, "R4 zero write");
    repeat (10) @(negedge clk);
    chk_reg(3'd0, 32'h1, "R5 hold");

    // R8 shared interrupt
    wr(3'd3, 32'h3);
    chk_out(1'b0, 1'b1, '0, "R8 irq on");
    pins(16'h0002);
    pins(16'h0000);
    chk_reg(3'd0, 32'h3, "R1 second falling edge");
    wr(3'd0, 32'h1);
    chk_out(1'b0, 1'b1, '0, "R8 irq kept by other flag");
    wr(3'd0, 32'h2);
    chk_out(1'b0, 1'b0, '0, "R8 irq off");

    // R11 / R6 non-maskable flag and layout
    nmi_pin(1'b1);
    chk_reg(3'd0, 32'h8000_0000, "R11 nmi flag at bit 31");
    chk_out(1'b1, 1'b0, '0, "R11 nmi output");
    wr(3'd3, 32'h0);
    nmi_pin(1'b0);
    chk_out(1'b1, 1'b0, '0, "R11 nmi ignores enables and falling edge");
    wr(3'd0, 32'h7FFF_0000);
    chk_reg(3'd0, 32'h8000_0000, "R6 reserved writes ignored");
    wr(3'd0, 32'hFFFF_FFFF);
    chk_reg(3'd0, 32'h0, "R6 clear all");
    chk_out(1'b0, 1'b0, '0, "R11 nmi cleared");

    // R9 DMA routing and acknowledge
    wr(3'd4, 32'h8);
    wr(3'd1, 32'h9);
    wr(3'd3, 32'hB);
    pins(16'h0008);
    chk_out(1'b0, 1'b0, 16'h0008, "R9 dma request, no irq");
    @(negedge clk); dma_ack_i = 16'h0008;
    @(negedge clk); dma_ack_i = '0;
    chk_reg(3'd0, 32'h0, "R9 ack clears flag");
    chk_out(1'b0, 1'b0, '0, "R9 dma request dropped");

    // R10 set beats write-one-clear
    pins(16'h000A);
    pins(16'h0008);
    chk_reg(3'd0, 32'h2, "R10 setup flag");
    wr(3'd1, 32'hB);
    @(negedge clk); irq_pin_i = 16'h000A;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h2;
    @(negedge clk); bus_wr = 1'b0;
    chk_reg(3'd0, 32'h2, "R10 set wins over w1c");

    // R10 set beats acknowledge
    @(negedge clk); irq_pin_i = 16'h0008;
    @(negedge clk);
    @(negedge clk); dma_ack_i = 16'h0002;
    @(negedge clk); dma_ack_i = '0;
    chk_reg(3'd0, 32'h2, "R10 set wins over ack");
    wr(3'd0, 32'h2);
    chk_reg(3'd0, 32'h0, "R4 clear after race");

    // R12 register map
    chk_reg(3'd1, 32'hB, "R12 rise readback");
    chk_reg(3'd2, 32'h2, "R12 fall readback");
    chk_reg(3'd3, 32'hB, "R12 request enable readback");
    chk_reg(3'd4, 32'h8, "R12 dma select readback");
    chk_reg(3'd7, 32'h0, "R12 unused index");

    @(negedge clk);
    #2;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule